// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block drives the two open-drain wires of an I2C bus as a bus master, one bus event at a time. Software writes a control register in which each event has its own one-shot trigger bit: Start, Repeated Start, Stop, receive one byte, and send one acknowledge bit. The engine runs the chosen sequence on SCL and SDA and then clears the trigger bit by itself. A write to the transmit register shifts one byte out and then clocks a ninth bit to read back the slave's acknowledge.

The acknowledge level sent after a received byte is held in its own control bit, apart from the trigger. It is used only right after a receive: an acknowledge trigger at any other time is dropped. Every released SCL level is read back from the wire before the timer counts, so a slave that holds SCL low stretches the clock. Each SCL phase lasts a parameter-set number of system clocks.

Register map (two-bit address): 0 control, 1 transmit byte, 2 received byte (read only), 3 status (read only). Control bits: bit 0 Start, bit 1 Repeated Start, bit 2 Stop, bit 3 receive, bit 4 acknowledge, bit 5 acknowledge level. Status bits: bit 0 busy, bit 1 slave answered NACK on the last transmit.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both SCL and SDA are released (not driven low), busy is 0 and all four registers read as 0.
- R2: Writing control bit 0 while idle pulls SDA low while SCL stays high, then pulls SCL low; control bit 0 reads 1 while this runs and 0 once it ends.
- R3: Control bit 1 releases SDA, then releases SCL (one clock with SDA high), then performs the Start sequence; the bit clears itself when done.
- R4: Control bit 2 drives SDA low with SCL low, releases SCL, then releases SDA while SCL is high; afterwards both lines stay released and the bit reads 0.
- R5: Control bit 3 clocks in eight bits with SDA released, most significant bit first, each sampled while SCL is high; the byte then reads at address 2 and bit 3 reads 0.
- R6: Control bit 4 clocks out one bit whose level is control bit 5 (0 pulls SDA low for ACK, 1 releases it for NACK); it is accepted only when the previous completed sequence was a receive, otherwise ignored, and bit 5 keeps its written value.
- R7: A write to address 1 while idle sends that byte most significant bit first, then clocks a ninth bit with SDA released and stores the sampled level in status bit 1 (1 = NACK).
- R8: While busy, writes to addresses 0 and 1 are ignored; when an idle control write sets several trigger bits, only the lowest-numbered one runs, and at most one trigger bit reads 1.
- R9: Status bit 0 and the busy output are 1 from the cycle after an accepted write until the sequence ends.
- R10: While the engine releases SCL but the wire stays low, the sequence holds; every SCL high time lasts at least HALF_CLKS system clocks.
- R11: Inside receive, transmit and acknowledge bits, SDA changes only while SCL is low, so the bus shows no Start or Stop other than those requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| scl_i | input | 1 | Level sensed on the SCL wire |
| sda_i | input | 1 | Level sensed on the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A sequence is in progress |

## Verification
A wrong phase index or command state shows on the wires within one SCL phase as a missing, extra or misplaced bit, or as a spurious Start or Stop. The bench decodes the bus into Start, Stop and sampled-bit events and compares them in order against what each command should produce. A stuck trigger bit or a lost busy shows at the next control read or a few cycles later on the busy pin. A corrupted shift register shows only at the end of the byte, in the receive register or the NACK flag.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

   localparam int BYTE_W = 8;
   localparam int PH_W   = 5;

   typedef enum logic [2:0] {
      CMD_IDLE   = 3'd0,
      CMD_START  = 3'd1,
      CMD_RSTART = 3'd2,
      CMD_STOP   = 3'd3,
      CMD_RX     = 3'd4,
      CMD_ACK    = 3'd5,
      CMD_TX     = 3'd6
   } cmd_e;

   // released = 1, pulled low = 0
   typedef struct packed {
      logic scl;
      logic sda;
   } lines_t;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_TXD  = 2'd1;
   localparam logic [1:0] REG_RXD  = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int C_START  = 0;
   localparam int C_RSTART = 1;
   localparam int C_STOP   = 2;
   localparam int C_RX     = 3;
   localparam int C_ACK    = 4;
   localparam int C_ACKLVL = 5;

   localparam int S_BUSY = 0;
   localparam int S_NACK = 1;

   function automatic logic [PH_W-1:0] last_phase(cmd_e c);
      case (c)
         CMD_START:  return 5'd1;
         CMD_RSTART: return 5'd3;
         CMD_STOP:   return 5'd2;
         CMD_RX:     return 5'd16;
         CMD_ACK:    return 5'd2;
         CMD_TX:     return 5'd18;
         default:    return 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/i2c_cmd_sync.sv
module i2c_cmd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q <= '1;
            end else begin
               r_q[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  r_q[i] <= r_q[i-1];
               end
            end
         end
         assign q = r_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_cmd_timer.sv
module i2c_cmd_timer #(
   parameter int HALF_CLKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic scl_want,
   input  logic scl_seen,
   output logic phase_end
);
   localparam int CW = $clog2(HALF_CLKS + 1);

   logic [CW-1:0] cnt_q;
   logic          hold;

   // a released SCL that still reads low means a slave is stretching
   assign hold      = scl_want && !scl_seen;
   assign phase_end = run && !hold && (cnt_q == CW'(HALF_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (!run || hold || phase_end) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
   end

   p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(HALF_CLKS));

   p_hold_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && scl_want && !scl_seen) |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_cmd_pattern.sv
module i2c_cmd_pattern
   import i2c_cmd_pkg::*;
(
   input  cmd_e              cmd,
   input  logic [PH_W-1:0]   ph,
   input  logic [BYTE_W-1:0] txd,
   input  logic              ack_lvl,
   output lines_t            want,
   output logic              samp_rx,
   output logic              samp_ack
);
   logic [2:0] bit_idx;

   assign bit_idx = 3'd7 - ph[3:1];

   always_comb begin
      want     = '{scl: 1'b1, sda: 1'b1};
      samp_rx  = 1'b0;
      samp_ack = 1'b0;
      case (cmd)
         CMD_START: begin
            want.scl = (ph == 5'd0);
            want.sda = 1'b0;
         end
         CMD_RSTART: begin
            want.scl = (ph == 5'd1) || (ph == 5'd2);
            want.sda = (ph < 5'd2);
         end
         CMD_STOP: begin
            want.scl = (ph != 5'd0);
            want.sda = (ph == 5'd2);
         end
         CMD_RX: begin
            want.sda = 1'b1;
            if (ph < 5'd16) begin
               want.scl = ph[0];
               samp_rx  = ph[0];
            end else begin
               want.scl = 1'b0;
            end
         end
         CMD_ACK: begin
            want.scl = (ph == 5'd1);
            want.sda = ack_lvl;
         end
         CMD_TX: begin
            if (ph < 5'd16) begin
               want.scl = ph[0];
               want.sda = txd[bit_idx];
            end else if (ph < 5'd18) begin
               want.scl = ph[0];
               want.sda = 1'b1;
               samp_ack = (ph == 5'd17);
            end else begin
               want.scl = 1'b0;
               want.sda = 1'b1;
            end
         end
         default: want = '{scl: 1'b1, sda: 1'b1};
      endcase
   end
endmodule

// File: rtl/i2c_cmd_core.sv
module i2c_cmd_core
   import i2c_cmd_pkg::*;
#(
   parameter int HALF_CLKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              scl_s,
   input  logic              sda_s,
   output logic              scl_rel,
   output logic              sda_rel,
   output logic              busy
);
   cmd_e              cmd_q, req_cmd;
   logic [PH_W-1:0]   ph_q;
   logic [BYTE_W-1:0] txd_q, rx_sh_q, rxd_q;
   logic              ack_lvl_q, nack_q, rx_pend_q;
   logic              scl_rel_q, sda_rel_q;
   logic              ctrl_wr, tx_wr, phase_end, last_ph;
   logic              samp_rx, samp_ack;
   lines_t            want;
   logic [BYTE_W-1:0] ctrl_rd, stat_rd;

   assign busy    = (cmd_q != CMD_IDLE);
   assign ctrl_wr = wr_en && (wr_addr == REG_CTRL) && !busy;
   assign tx_wr   = wr_en && (wr_addr == REG_TXD)  && !busy;
   assign last_ph = (ph_q == last_phase(cmd_q));

   // lowest-numbered trigger wins; acknowledge only right after a receive
   always_comb begin
      req_cmd = CMD_IDLE;
      if (ctrl_wr) begin
         if      (wr_data[C_START])               req_cmd = CMD_START;
         else if (wr_data[C_RSTART])              req_cmd = CMD_RSTART;
         else if (wr_data[C_STOP])                req_cmd = CMD_STOP;
         else if (wr_data[C_RX])                  req_cmd = CMD_RX;
         else if (wr_data[C_ACK] && rx_pend_q)    req_cmd = CMD_ACK;
      end else if (tx_wr) begin
         req_cmd = CMD_TX;
      end
   end

   i2c_cmd_pattern u_pattern (
      .cmd      (cmd_q),
      .ph       (ph_q),
      .txd      (txd_q),
      .ack_lvl  (ack_lvl_q),
      .want     (want),
      .samp_rx  (samp_rx),
      .samp_ack (samp_ack)
   );

   i2c_cmd_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .scl_want  (want.scl),
      .scl_seen  (scl_s),
      .phase_end (phase_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= CMD_IDLE;
         ph_q      <= '0;
         txd_q     <= '0;
         rx_sh_q   <= '0;
         rxd_q     <= '0;
         ack_lvl_q <= 1'b0;
         nack_q    <= 1'b0;
         rx_pend_q <= 1'b0;
      end else begin
         if (ctrl_wr) ack_lvl_q <= wr_data[C_ACKLVL];
         if (tx_wr)   txd_q     <= wr_data;
         if (req_cmd != CMD_IDLE) begin
            cmd_q     <= req_cmd;
            ph_q      <= '0;
            rx_pend_q <= 1'b0;
         end else if (busy && phase_end) begin
            if (samp_rx)  rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_s};
            if (samp_ack) nack_q  <= sda_s;
            if (last_ph) begin
               cmd_q <= CMD_IDLE;
               ph_q  <= '0;
               if (cmd_q == CMD_RX) begin
                  rxd_q     <= rx_sh_q;
                  rx_pend_q <= 1'b1;
               end
            end else begin
               ph_q <= ph_q + 1'b1;
            end
         end
      end
   end

   // SDA follows the pattern only while SCL is already low, or when the
   // phase deliberately keeps SCL high (Start/Stop edges); on an SCL fall
   // SDA therefore moves one clock later.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_rel_q <= 1'b1;
         sda_rel_q <= 1'b1;
      end else if (busy) begin
         scl_rel_q <= want.scl;
         if (!scl_rel_q || want.scl) sda_rel_q <= want.sda;
      end
   end

   assign scl_rel = scl_rel_q;
   assign sda_rel = sda_rel_q;

   assign ctrl_rd = {2'b00, ack_lvl_q,
                     cmd_q == CMD_ACK, cmd_q == CMD_RX, cmd_q == CMD_STOP,
                     cmd_q == CMD_RSTART, cmd_q == CMD_START};
   assign stat_rd = {6'd0, nack_q, busy};

   always_comb begin
      case (rd_addr)
         REG_CTRL: rd_data = ctrl_rd;
         REG_TXD:  rd_data = txd_q;
         REG_RXD:  rd_data = rxd_q;
         default:  rd_data = stat_rd;
      endcase
   end

   p_busy_tx_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && wr_addr == REG_TXD) |=> $stable(txd_q));

   p_cmd_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(phase_end && last_ph)) |=> (cmd_q == $past(cmd_q)));

   p_ack_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rx_pend_q) |=> (cmd_q != CMD_ACK));

   p_stretch_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && want.scl && !scl_s) |=> $stable(ph_q));

   p_sda_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_rel_q) |-> $stable(sda_rel_q));

   p_stop_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_q) == CMD_STOP && cmd_q == CMD_IDLE) |-> (scl_rel_q && sda_rel_q));

   p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(scl_rel_q) || busy));

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
   import i2c_cmd_pkg::*;
#(
   parameter int HALF_CLKS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [1:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       busy
);
   generate
      if (HALF_CLKS < 2) begin : g_bad_half
         $error("HALF_CLKS must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic scl_s, sda_s, scl_rel, sda_rel;

   i2c_cmd_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));

   i2c_cmd_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2c_cmd_core #(.HALF_CLKS(HALF_CLKS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .scl_s   (scl_s),
      .sda_s   (sda_s),
      .scl_rel (scl_rel),
      .sda_rel (sda_rel),
      .busy    (busy)
   );

   assign scl_oe = !scl_rel;
   assign sda_oe = !sda_rel;

endmodule

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
   localparam int HALF = 8;
   localparam int EV_START = 0, EV_STOP = 1, EV_B0 = 2, EV_B1 = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       scl_oe, sda_oe, busy;
   logic       scl_line, sda_line;

   logic slv_lvl = 1'b1;
   bit   slv_q[$];
   int   slv_falls = 0;
   int   stretch_at = -1;
   int   stretch_cnt = 0;

   int    exp_q[$];
   string tag_q[$];
   int    checks = 0, errors = 0;
   logic  prev_scl = 1'b1, prev_sda = 1'b1;
   int    hi_run = 0, min_hi = 1000;

   always #10 clk = ~clk;

   assign scl_line = !scl_oe && (stretch_cnt == 0);
   assign sda_line = !sda_oe && slv_lvl;

   i2c_cmd_master #(.HALF_CLKS(HALF), .SYNC_STAGES(2)) u_i2c_cmd_master (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .busy(busy));

   task automatic expect_ev(int ev, string tag);
      exp_q.push_back(ev);
      tag_q.push_back(tag);
   endtask

   task automatic expect_byte(logic [7:0] b, string tag);
      for (int i = 7; i >= 0; i--) expect_ev(b[i] ? EV_B1 : EV_B0, tag);
   endtask

   task automatic got(int ev);
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL bus: unexpected event actual=%0d expected=none", ev);
      end else begin
         int    e = exp_q.pop_front();
         string t = tag_q.pop_front();
         if (e != ev) begin
            errors++;
            $display("FAIL %s: bus event actual=%0d expected=%0d", t, ev, e);
         end
      end
   endtask

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bus monitor and slave model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_line && prev_scl && prev_sda && !sda_line) got(EV_START);
         if (scl_line && prev_scl && !prev_sda && sda_line) got(EV_STOP);
         if (scl_line && !prev_scl) got(sda_line ? EV_B1 : EV_B0);
         if (scl_line) hi_run <= hi_run + 1;
         else begin
            if (prev_scl && hi_run < min_hi) min_hi <= hi_run;
            hi_run <= 0;
         end
         if (!scl_line && prev_scl) begin
            slv_falls <= slv_falls + 1;
            if (slv_q.size() > 0) slv_lvl <= slv_q.pop_front();
            else                  slv_lvl <= 1'b1;
            if (slv_falls + 1 == stretch_at) stretch_cnt <= 40;
         end else if (stretch_cnt > 0) begin
            stretch_cnt <= stretch_cnt - 1;
         end
         prev_scl <= scl_line;
         prev_sda <= sda_line;
      end
   end

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
   endtask

   // slave presents byte b on a receive
   task automatic slave_send(logic [7:0] b, int stretch_fall);
      slv_q.delete();
      for (int i = 6; i >= 0; i--) slv_q.push_back(b[i]);
      slv_q.push_back(1'b1);
      @(negedge clk);
      slv_lvl <= b[7];
      slv_falls <= 0;
      stretch_at <= stretch_fall;
   endtask

   // slave answers a transmit with ACK (ack=1) or NACK
   task automatic slave_listen(bit ack);
      slv_q.delete();
      for (int i = 0; i < 7; i++) slv_q.push_back(1'b1);
      slv_q.push_back(!ack);
      slv_q.push_back(1'b1);
      @(negedge clk);
      slv_lvl <= 1'b1;
      slv_falls <= 0;
      stretch_at <= -1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk("R1 lines", {6'd0, scl_line, sda_line}, 8'h03);
      chk("R1 busy", {7'd0, busy}, 8'h00);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 reg", d, 8'h00);
      end

      // R2 start
      expect_ev(EV_START, "R2");
      wr(2'd0, 8'h01);
      rd(2'd0, d);
      chk("R2 bit set while running", d, 8'h01);
      wait_idle();
      rd(2'd0, d);
      chk("R2 self-clear", d, 8'h00);

      // R7 transmit with ACK
      slave_listen(1'b1);
      expect_byte(8'hA5, "R7");
      expect_ev(EV_B0, "R7 ack");
      wr(2'd1, 8'hA5);
      wait_idle();
      rd(2'd3, d);
      chk("R7 ack seen", d, 8'h00);

      // R7 NACK, R8 writes while busy ignored, R9 busy
      slave_listen(1'b0);
      expect_byte(8'h3C, "R7");
      expect_ev(EV_B1, "R7 nack");
      wr(2'd1, 8'h3C);
      chk("R9 busy pin", {7'd0, busy}, 8'h01);
      rd(2'd3, d);
      chk("R9 busy status", d & 8'h01, 8'h01);
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'h24);
      rd(2'd0, d);
      chk("R8 ctrl write ignored while busy", d, 8'h00);
      wait_idle();
      rd(2'd1, d);
      chk("R8 tx write ignored while busy", d, 8'h3C);
      rd(2'd3, d);
      chk("R7 nack flag", d, 8'h02);
      chk("R9 busy cleared", {7'd0, busy}, 8'h00);

      // R3 repeated start
      expect_ev(EV_B1, "R3");
      expect_ev(EV_START, "R3");
      wr(2'd0, 8'h02);
      wait_idle();
      rd(2'd0, d);
      chk("R3 self-clear", d, 8'h00);

      // R6 acknowledge without preceding receive is ignored
      wr(2'd0, 8'h10);
      repeat (3) @(negedge clk);
      chk("R6 ack ignored busy", {7'd0, busy}, 8'h00);
      rd(2'd0, d);
      chk("R6 ack ignored ctrl", d, 8'h00);

      // R5 receive
      slave_send(8'h96, -1);
      expect_byte(8'h96, "R5");
      wr(2'd0, 8'h08);
      wait_idle();
      rd(2'd2, d);
      chk("R5 rx byte", d, 8'h96);
      rd(2'd0, d);
      chk("R5 self-clear", d, 8'h00);

      // R6 ACK level 0
      expect_ev(EV_B0, "R6 ack");
      wr(2'd0, 8'h10);
      wait_idle();
      rd(2'd0, d);
      chk("R6 ack self-clear", d, 8'h00);

      // R5/R10 receive with clock stretch
      slave_send(8'h3B, 3);
      expect_byte(8'h3B, "R10");
      wr(2'd0, 8'h08);
      wait_idle();
      rd(2'd2, d);
      chk("R5 rx byte stretched", d, 8'h3B);
      checks++;
      if (min_hi < HALF) begin
         errors++;
         $display("FAIL R10: min SCL high actual=%0d expected>=%0d", min_hi, HALF);
      end

      // R6 NACK level 1
      expect_ev(EV_B1, "R6 nack");
      wr(2'd0, 8'h30);
      wait_idle();
      rd(2'd0, d);
      chk("R6 ack level kept", d, 8'h20);

      // R8 several triggers: lowest wins (repeated start over stop)
      expect_ev(EV_B1, "R8");
      expect_ev(EV_START, "R8");
      wr(2'd0, 8'h06);
      rd(2'd0, d);
      chk("R8 one trigger bit", d, 8'h02);
      wait_idle();

      // R4 stop
      expect_ev(EV_B0, "R4");
      expect_ev(EV_STOP, "R4");
      wr(2'd0, 8'h04);
      wait_idle();
      rd(2'd0, d);
      chk("R4 self-clear", d, 8'h00);
      chk("R4 lines released", {6'd0, scl_line, sda_line}, 8'h03);

      // R11 every expected event consumed, no stray Start/Stop
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11: pending events actual=%0d expected=0", exp_q.size());
      end
      checks++;
      if (min_hi < HALF) begin
         errors++;
         $display("FAIL R10: min SCL high actual=%0d expected>=%0d", min_hi, HALF);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule